// File: doc/BRIEF.md
# Receive Clock Phase Training Controller

This block trains the receive sampling phase of a source-synchronous parallel die-to-die link. It runs while the link is being brought up, before any payload moves. On a start pulse it asks the far transmitter to emit a PRBS-7 pattern. It then moves a 6-bit receive-clock delay code through every tap, beginning at 0. At each tap it waits a programmable settle time. It then loads a local PRBS reference from the incoming bits and checks a programmable number of further bits against that reference.

The controller keeps the first run of error-free taps, which is the data eye. It then drives the delay code to the middle of that run and raises a done flag. If no tap is error-free, it raises both fail and done and returns the code to zero. The analog delay line and the I/O cells lie outside the block. The delay code drives the delay line, and the sampled data input carries one received bit per clock.

Top module: `rx_phase_trainer`

## Requirements
- R1: After reset, the delay code is 0, and the done, fail and PRBS request outputs are low.
- R2: A start pulse accepted while idle or finished raises the PRBS request and sweeps the delay code upward from 0, one tap at a time. The request stays high for the whole sweep.
- R3: With settle setting S and dwell setting N (N at least 1), each tap holds the delay code for exactly S+N+9 clock cycles. These are S+1 settle cycles, 7 seeding cycles, N checking cycles and one evaluation cycle.
- R4: At each tap, the checker loads its reference from the first 7 received bits. It then checks each later bit against the PRBS-7 rule (x^7+x^6+1: bit n equals bit n-6 XOR bit n-7). Any mismatch marks the tap as having errors.
- R5: The eye's left edge is the first error-free tap. The right edge is the last tap of the unbroken error-free run that starts there. Error-free taps after that run do not affect the result.
- R6: When the eye is found, the final delay code is (left+right)/2 rounded down, done goes high, fail stays low and the PRBS request drops.
- R7: When no tap is error-free, fail and done both go high and the delay code is 0.
- R8: A start pulse during a sweep is ignored, and the delay code does not return to 0.
- R9: An error-free run that reaches tap 63 ends there, and the sweep finishes after tap 63.
- R10: The done, fail and delay code outputs hold their values until the next accepted start. A restart clears fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a training sweep |
| settle_i | input | 16 | Settle setting S; the block waits S+1 cycles after each tap change |
| dwell_i | input | 16 | Number of bits checked per tap (N) |
| rx_bit_i | input | 1 | Received bit sampled by the delayed clock |
| prbs_req_o | output | 1 | Asks the transmitter to send PRBS-7 |
| delay_code_o | output | 6 | Receive-clock delay tap |
| done_o | output | 1 | Training finished |
| fail_o | output | 1 | No error-free tap was found |

## Verification
Every output is registered. The delay code moves one clock edge after the evaluation cycle of each tap, so a tap lasts S+N+9 cycles. The bench measures this span by counting falling edges between two code changes. Done, fail and the centred code appear together two edges after the last evaluation. The bench polls them on falling edges and checks them once done is seen. It also checks that they stay unchanged for a later stretch of cycles. The delay-line stub drives the received bit on the falling edge from the current code, so every bit sampled after a code change already reflects the new tap.

// File: rtl/rx_phase_trainer_pkg.sv
package rx_phase_trainer_pkg;
    localparam int PRBS_LEN = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEED,
        ST_DWELL,
        ST_EVAL,
        ST_FINISH,
        ST_DONE
    } trn_state_e;
endpackage

// File: rtl/rx_prbs7_check.sv
module rx_prbs7_check
    import rx_phase_trainer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic seed_i,
    input  logic check_i,
    input  logic bit_i,
    output logic err_o
);
    typedef struct packed {
        logic [PRBS_LEN-1:0] sr;
        logic                err;
    } chk_t;

    chk_t q, d;
    logic predicted;

    always_comb begin
        d = q;
        predicted = q.sr[PRBS_LEN-1] ^ q.sr[PRBS_LEN-2];
        if (clear_i) begin
            d = '0;
        end else if (seed_i) begin
            d.sr = {q.sr[PRBS_LEN-2:0], bit_i};
        end else if (check_i) begin
            d.sr = {q.sr[PRBS_LEN-2:0], bit_i};
            if (bit_i != predicted) d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err_o = q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !clear_i) |=> q.err); // R4
endmodule

// File: rtl/rx_eye_window.sv
module rx_eye_window #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             eval_i,
    input  logic             clean_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic             found_o,
    output logic [TAP_W-1:0] left_o,
    output logic [TAP_W-1:0] right_o
);
    typedef struct packed {
        logic             found;
        logic             closed;
        logic [TAP_W-1:0] left;
        logic [TAP_W-1:0] right;
    } eye_t;

    eye_t q, d;

    always_comb begin
        d = q;
        if (clear_i) begin
            d = '0;
        end else if (eval_i) begin
            if (clean_i) begin
                if (!q.found) begin
                    d.found = 1'b1;
                    d.left  = tap_i;
                    d.right = tap_i;
                end else if (!q.closed) begin
                    d.right = tap_i;
                end
            end else if (q.found) begin
                d.closed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign found_o = q.found;
    assign left_o  = q.left;
    assign right_o = q.right;

    AST_LEFT_NOT_PAST_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        q.found |-> (q.left <= q.right)); // R5
    AST_EDGES_FROZEN_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.closed && !clear_i) |=> ($stable(q.left) && $stable(q.right))); // R5
endmodule

// File: rtl/rx_phase_trainer.sv
module rx_phase_trainer
    import rx_phase_trainer_pkg::*;
#(
    parameter int TAP_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] settle_i,
    input  logic [CNT_W-1:0] dwell_i,
    input  logic             rx_bit_i,
    output logic             prbs_req_o,
    output logic [TAP_W-1:0] delay_code_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam logic [TAP_W-1:0] LAST_TAP = {TAP_W{1'b1}};
    localparam logic [CNT_W-1:0] SEED_END = CNT_W'(PRBS_LEN - 1);

    typedef struct packed {
        trn_state_e       st;
        logic [TAP_W-1:0] tap;
        logic [CNT_W-1:0] cnt;
        logic [TAP_W-1:0] delay;
        logic             done;
        logic             fail;
        logic             req;
    } fsm_t;

    fsm_t q, d;

    logic             accept;
    logic             tap_err;
    logic             eye_found;
    logic [TAP_W-1:0] eye_left;
    logic [TAP_W-1:0] eye_right;
    logic [TAP_W:0]   edge_sum;
    logic [CNT_W:0]   dwell_next;

    assign accept     = start_i && ((q.st == ST_IDLE) || (q.st == ST_DONE));
    assign edge_sum   = {1'b0, eye_left} + {1'b0, eye_right};
    assign dwell_next = {1'b0, q.cnt} + (CNT_W+1)'(1);

    rx_prbs7_check u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (q.st == ST_SETTLE),
        .seed_i  (q.st == ST_SEED),
        .check_i (q.st == ST_DWELL),
        .bit_i   (rx_bit_i),
        .err_o   (tap_err)
    );

    rx_eye_window #(.TAP_W(TAP_W)) u_eye (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .eval_i  (q.st == ST_EVAL),
        .clean_i (!tap_err),
        .tap_i   (q.tap),
        .found_o (eye_found),
        .left_o  (eye_left),
        .right_o (eye_right)
    );

    always_comb begin
        d = q;
        if (accept) begin
            d.st    = ST_SETTLE;
            d.tap   = '0;
            d.cnt   = '0;
            d.delay = '0;
            d.done  = 1'b0;
            d.fail  = 1'b0;
            d.req   = 1'b1;
        end else begin
            case (q.st)
                ST_SETTLE: begin
                    if (q.cnt == settle_i) begin
                        d.st  = ST_SEED;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_SEED: begin
                    if (q.cnt == SEED_END) begin
                        d.st  = ST_DWELL;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_DWELL: begin
                    if (dwell_next >= {1'b0, dwell_i}) begin
                        d.st  = ST_EVAL;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_EVAL: begin
                    if ((q.tap == LAST_TAP) || (eye_found && tap_err)) begin
                        d.st = ST_FINISH;
                    end else begin
                        d.st    = ST_SETTLE;
                        d.tap   = q.tap + TAP_W'(1);
                        d.delay = q.tap + TAP_W'(1);
                    end
                end
                ST_FINISH: begin
                    d.st   = ST_DONE;
                    d.done = 1'b1;
                    d.req  = 1'b0;
                    if (eye_found) begin
                        d.delay = edge_sum[TAP_W:1];
                        d.fail  = 1'b0;
                    end else begin
                        d.delay = '0;
                        d.fail  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign prbs_req_o   = q.req;
    assign delay_code_o = q.delay;
    assign done_o       = q.done;
    assign fail_o       = q.fail;

    AST_FAIL_PARKS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (done_o && delay_code_o == '0)); // R7
    AST_REQ_LOW_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !prbs_req_o); // R6
    AST_SWEEP_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_req_o && $past(prbs_req_o) && !done_o && !$past(done_o))
            |-> (delay_code_o >= $past(delay_code_o))); // R2
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && prbs_req_o && q.st != ST_FINISH && delay_code_o != '0)
            |=> (delay_code_o != '0)); // R8
endmodule

// File: tb/rx_phase_trainer_bench.sv
module rx_phase_trainer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] settle_i = 16'd2;
    logic [15:0] dwell_i = 16'd16;
    logic        rx_bit_i = 1'b0;
    logic        prbs_req_o;
    logic [5:0]  delay_code_o;
    logic        done_o;
    logic        fail_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int lo0 = 1, hi0 = 0, lo1 = 1, hi1 = 0;
    logic [6:0] gen = 7'h5A;

    always #2 clk = ~clk;

    rx_phase_trainer u_rx_phase_trainer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .settle_i     (settle_i),
        .dwell_i      (dwell_i),
        .rx_bit_i     (rx_bit_i),
        .prbs_req_o   (prbs_req_o),
        .delay_code_o (delay_code_o),
        .done_o       (done_o),
        .fail_o       (fail_o)
    );

    function automatic bit in_eye(int c);
        return (c >= lo0 && c <= hi0) || (c >= lo1 && c <= hi1);
    endfunction

    // Stub for the delay line and I/O cells: PRBS-7 source with errors outside the eye
    always @(negedge clk) begin
        logic nb;
        cyc = cyc + 1;
        nb = gen[6] ^ gen[5];
        gen = {gen[5:0], nb};
        rx_bit_i = nb ^ (!in_eye(int'(delay_code_o)) && (cyc % 3 == 0));
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!done_o && n < 5000) begin @(negedge clk); n++; end
        chk(done_o == 1'b1, {req, " done reached"}, int'(done_o), 1);
    endtask

    task automatic run_eye(int a0, int b0, int a1, int b1, int exp_code, bit exp_fail, string req);
        lo0 = a0; hi0 = b0; lo1 = a1; hi1 = b1;
        pulse_start();
        wait_done(req);
        chk(fail_o == exp_fail, {req, " fail flag"}, int'(fail_o), int'(exp_fail));
        chk(int'(delay_code_o) == exp_code, {req, " delay code"}, int'(delay_code_o), exp_code);
        chk(prbs_req_o == 1'b0, {req, " prbs request dropped"}, int'(prbs_req_o), 0);
    endtask

    task automatic t_reset();
        chk(delay_code_o == 6'd0, "R1 delay code", int'(delay_code_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(fail_o == 1'b0, "R1 fail", int'(fail_o), 0);
        chk(prbs_req_o == 1'b0, "R1 prbs request", int'(prbs_req_o), 0);
    endtask

    task automatic t_sweep_timing();
        int span = 0;
        settle_i = 16'd3; dwell_i = 16'd12;
        lo0 = 10; hi0 = 30; lo1 = 1; hi1 = 0;
        pulse_start();
        chk(prbs_req_o == 1'b1, "R2 request raised", int'(prbs_req_o), 1);
        chk(delay_code_o == 6'd0, "R2 sweep begins at tap 0", int'(delay_code_o), 0);
        while (delay_code_o != 6'd1) @(negedge clk);
        while (delay_code_o != 6'd2) begin @(negedge clk); span++; end
        chk(span == 24, "R3 cycles per tap", span, 24);
        while (delay_code_o != 6'd5) @(negedge clk);
        chk(prbs_req_o == 1'b1, "R2 request held mid sweep", int'(prbs_req_o), 1);
        pulse_start();
        repeat (2) @(negedge clk);
        chk(delay_code_o >= 6'd5, "R8 start ignored while busy", int'(delay_code_o), 5);
        wait_done("R6 R4 eye 10..30");
        chk(int'(delay_code_o) == 20, "R6 centre of 10..30", int'(delay_code_o), 20);
        chk(fail_o == 1'b0, "R6 no fail", int'(fail_o), 0);
        settle_i = 16'd2; dwell_i = 16'd16;
    endtask

    task automatic t_hold();
        logic [5:0] code = delay_code_o;
        repeat (40) @(negedge clk);
        chk(done_o == 1'b1 && delay_code_o == code, "R10 result held", int'(delay_code_o), int'(code));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep_timing();
        t_hold();
        run_eye(0, 5, 1, 0, 2, 1'b0, "R6 round down 0..5");
        run_eye(7, 8, 1, 0, 7, 1'b0, "R6 R4 narrow eye 7..8");
        run_eye(5, 9, 20, 40, 7, 1'b0, "R5 second window ignored");
        run_eye(50, 63, 1, 0, 56, 1'b0, "R9 eye open at last tap");
        run_eye(1, 0, 1, 0, 0, 1'b1, "R7 no clean tap");
        t_hold();
        run_eye(12, 14, 1, 0, 13, 1'b0, "R10 restart after fail");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule